// File: doc/BRIEF.md
# Switch configuration upload sequencer

This block brings an attached switch device from live operation into a freshly programmed state. A single pulse on `start` launches the sequence. First, transmit is silenced on every port through a read-modify-write of the port-control register. The block then waits for any frame still on the wire to finish and issues a cold reset. After the device has had time to recover, the block hands the configuration image to an external chunked burst engine. Once the upload is complete, it reads back a status word to judge the result.

Register traffic leaves the block on a single request/done access port. The request is a level that is held until the device side answers. The burst engine is driven by a second level handshake. A failure in the reset write, the upload, the status read, or any of the validation bits sends the block back to the cold reset for another attempt, up to a parameterised limit. A failed inhibit step ends the run at once.

The end of a run is marked by a one-cycle `done` pulse. The outcome, the number of attempts used and a code for the last failing check are held after that pulse until the next start. Both wait intervals are derived from a clock-frequency parameter.

Top module: `cfg_upload_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `reg_req` and `upl_req` are low.
- R2: A run begins with a read of PORT_CTRL_ADDR, followed by a write to the same address of the value read with bits 0 to NUM_PORTS-1 forced to one.
- R3: An error on either inhibit access ends the run with `done`, `ok`=0, `err_code`=1 and `attempts`=0, and no reset-control write is issued.
- R4: Between the completion of the inhibit write and the cold-reset request, at least DRAIN_US microseconds of clock cycles pass.
- R5: The cold reset is a write to RST_CTRL_ADDR of a word with exactly one bit set: bit 3 when `rst_bit_sel` is 0, and bit 2 when it is 1.
- R6: Between the completion of a successful reset write and the upload request, at least RECOVER_US microseconds of clock cycles pass.
- R7: After a successful upload, the block reads STATUS_ADDR, and it never requests a register access and an upload at the same time.
- R8: The status word passes when bit 31 is set and bits 30, 29 and 28 are all clear, with all other bits ignored. A pass ends the run with `ok`=1, `err_code`=0 and `attempts` equal to the number of cold resets issued.
- R9: A failing status word sets `err_code` in this order of priority: bit 29 set gives 5, bit 30 set gives 6, bit 28 set gives 7, and bit 31 clear gives 8.
- R10: A reset-write error (code 2), an upload error (code 3), a status-read error (code 4) or a failing status word restarts the run from the cold reset, without repeating the inhibit step.
- R11: When attempt MAX_TRIES fails, the run ends with `ok`=0, `attempts`=MAX_TRIES and `err_code` set to the cause of that last failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that launches a run while idle |
| rst_bit_sel | input | 1 | Chooses the cold-reset bit (0: bit 3, 1: bit 2), held stable while busy |
| reg_req | output | 1 | Register access request, held until `reg_done` |
| reg_write | output | 1 | 1 for a write access, 0 for a read access |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 32 | Write data |
| reg_done | input | 1 | Access completed (one cycle) |
| reg_err | input | 1 | Access failed, valid with `reg_done` |
| reg_rdata | input | 32 | Read data, valid with `reg_done` |
| upl_req | output | 1 | Upload request to the burst engine, held until `upl_done` |
| upl_done | input | 1 | Upload completed (one cycle) |
| upl_err | input | 1 | Upload failed, valid with `upl_done` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| ok | output | 1 | Outcome of the last run |
| attempts | output | $clog2(MAX_TRIES+1) | Cold resets issued in the last run |
| err_code | output | 4 | Cause of the last failing check, 0 when none |

## Verification
The hardest situation to reach is a run that fails in a different way on each of several attempts and then succeeds. Each retry must re-enter at the cold reset, and the cause code must be overwritten on every pass. The bench's device model holds a separate failure mask for each attempt, covering reset errors, upload errors and status-read errors, plus a status word for each attempt. These are indexed by how many reset writes the model has seen, so one run can walk through every retry path before it passes. The same model drives the exhaustion runs, with a chosen status pattern on the tenth attempt.

// File: rtl/cfg_upload_seq.sv
module cfg_upload_seq #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int DRAIN_US    = 500,
  parameter int RECOVER_US  = 1000,
  parameter int NUM_PORTS   = 5,
  parameter int MAX_TRIES   = 10,
  parameter int ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] PORT_CTRL_ADDR = 'h11,
  parameter logic [ADDR_W-1:0] RST_CTRL_ADDR  = 'h100440,
  parameter logic [ADDR_W-1:0] STATUS_ADDR    = 'h1,
  localparam int AW = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rst_bit_sel,
  output logic              reg_req,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [31:0]       reg_wdata,
  input  logic              reg_done,
  input  logic              reg_err,
  input  logic [31:0]       reg_rdata,
  output logic              upl_req,
  input  logic              upl_done,
  input  logic              upl_err,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [AW-1:0]     attempts,
  output logic [3:0]        err_code
);

  localparam int CYC_US      = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int DRAIN_CYC   = CYC_US * DRAIN_US;
  localparam int RECOVER_CYC = CYC_US * RECOVER_US;
  localparam int WAIT_MAX    = (DRAIN_CYC > RECOVER_CYC) ? DRAIN_CYC : RECOVER_CYC;
  localparam int TW          = $clog2(WAIT_MAX + 1);
  localparam logic [31:0] PORT_MASK = 32'((64'd1 << NUM_PORTS) - 64'd1);

  localparam logic [3:0] C_NONE = 4'd0, C_INHIBIT = 4'd1, C_RESET = 4'd2, C_UPLOAD = 4'd3,
                         C_STAT_RD = 4'd4, C_DEV_ID = 4'd5, C_LCRC = 4'd6, C_GCRC = 4'd7,
                         C_INVALID = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_PC_RD, S_PC_WR, S_DRAIN, S_RST, S_RECOVER, S_UPL, S_STAT
  } state_t;

  state_t          st;
  logic [TW-1:0]   cnt;
  logic [31:0]     pc_q;
  logic            fail;
  logic [3:0]      fail_code;

  assign busy      = (st != S_IDLE);
  assign reg_req   = (st == S_PC_RD) || (st == S_PC_WR) || (st == S_RST) || (st == S_STAT);
  assign reg_write = (st == S_PC_WR) || (st == S_RST);
  assign upl_req   = (st == S_UPL);
  assign reg_addr  = (st == S_RST)  ? RST_CTRL_ADDR :
                     (st == S_STAT) ? STATUS_ADDR : PORT_CTRL_ADDR;
  assign reg_wdata = (st == S_PC_WR) ? pc_q :
                     (st == S_RST)   ? (rst_bit_sel ? 32'h4 : 32'h8) : 32'h0;

  always_comb begin
    fail      = 1'b0;
    fail_code = C_NONE;
    case (st)
      S_PC_RD, S_PC_WR: begin fail = reg_done && reg_err; fail_code = C_INHIBIT; end
      S_RST:            begin fail = reg_done && reg_err; fail_code = C_RESET;   end
      S_UPL:            begin fail = upl_done && upl_err; fail_code = C_UPLOAD;  end
      S_STAT: if (reg_done) begin
        fail = 1'b1;
        if (reg_err)            fail_code = C_STAT_RD;
        else if (reg_rdata[29]) fail_code = C_DEV_ID;
        else if (reg_rdata[30]) fail_code = C_LCRC;
        else if (reg_rdata[28]) fail_code = C_GCRC;
        else if (!reg_rdata[31]) fail_code = C_INVALID;
        else fail = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      pc_q     <= '0;
      attempts <= '0;
      done     <= 1'b0;
      ok       <= 1'b0;
      err_code <= C_NONE;
    end else begin
      done <= 1'b0;
      if (fail) begin
        err_code <= fail_code;
        if (fail_code == C_INHIBIT || attempts == AW'(MAX_TRIES)) begin
          st   <= S_IDLE;
          done <= 1'b1;
          ok   <= 1'b0;
        end else begin
          st       <= S_RST;
          attempts <= attempts + 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: if (start) begin
            st       <= S_PC_RD;
            attempts <= '0;
            ok       <= 1'b0;
            err_code <= C_NONE;
          end
          S_PC_RD: if (reg_done) begin
            pc_q <= reg_rdata | PORT_MASK;
            st   <= S_PC_WR;
          end
          S_PC_WR: if (reg_done) begin
            cnt <= TW'(DRAIN_CYC);
            st  <= S_DRAIN;
          end
          S_DRAIN: if (cnt == '0) begin
            st       <= S_RST;
            attempts <= attempts + 1'b1;
          end else cnt <= cnt - 1'b1;
          S_RST: if (reg_done) begin
            cnt <= TW'(RECOVER_CYC);
            st  <= S_RECOVER;
          end
          S_RECOVER: if (cnt == '0) st <= S_UPL;
                     else cnt <= cnt - 1'b1;
          S_UPL: if (upl_done) st <= S_STAT;
          S_STAT: if (reg_done) begin
            st       <= S_IDLE;
            done     <= 1'b1;
            ok       <= 1'b1;
            err_code <= C_NONE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_upload_seq_chk.sv
module cfg_upload_seq_chk #(
  parameter int MAX_TRIES = 10,
  parameter int ADDR_W    = 24,
  parameter int AW        = 4,
  parameter logic [ADDR_W-1:0] RST_CTRL_ADDR = 'h100440
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_bit_sel,
  input logic              reg_req,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              reg_done,
  input logic              upl_req,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic [AW-1:0]     attempts,
  input logic [3:0]        err_code
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_req && !upl_req));

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_done) |=> (reg_req && $stable(reg_addr) && $stable(reg_write)));

  p_reset_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_write && reg_addr == RST_CTRL_ADDR) |->
      (reg_wdata == (rst_bit_sel ? 32'h4 : 32'h8)));

  p_one_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && upl_req));

  p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (err_code == 4'd0 && attempts != '0));

  p_fail_coded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> (err_code != 4'd0));

  p_attempt_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= AW'(MAX_TRIES));

endmodule

bind cfg_upload_seq cfg_upload_seq_chk #(
  .MAX_TRIES(MAX_TRIES), .ADDR_W(ADDR_W), .AW(AW), .RST_CTRL_ADDR(RST_CTRL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_bit_sel(rst_bit_sel), .reg_req(reg_req),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_done(reg_done), .upl_req(upl_req), .busy(busy), .done(done), .ok(ok),
  .attempts(attempts), .err_code(err_code)
);

// File: tb/cfg_upload_seq_tb.sv
module cfg_upload_seq_tb_top;
  localparam int CLK_PERIOD  = 10;
  localparam int CLK_HZ      = 1_000_000;
  localparam int DRAIN_US    = 500;
  localparam int RECOVER_US  = 1000;
  localparam int NUM_PORTS   = 5;
  localparam int MAX_TRIES   = 10;
  localparam int ADDR_W      = 24;
  localparam int AW          = $clog2(MAX_TRIES + 1);
  localparam int DRAIN_CYC   = DRAIN_US;
  localparam int RECOVER_CYC = RECOVER_US;
  localparam logic [ADDR_W-1:0] A_PC   = 'h11;
  localparam logic [ADDR_W-1:0] A_RST  = 'h100440;
  localparam logic [ADDR_W-1:0] A_STAT = 'h1;

  logic clk = 0, rst_n = 0, start = 0, rst_bit_sel = 0;
  logic reg_req, reg_write, upl_req, busy, done, ok;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata;
  logic reg_done = 0, reg_err = 0, upl_done = 0, upl_err = 0;
  logic [31:0] reg_rdata = 0;
  logic [AW-1:0] attempts;
  logic [3:0] err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_upload_seq #(
    .CLK_HZ(CLK_HZ), .DRAIN_US(DRAIN_US), .RECOVER_US(RECOVER_US),
    .NUM_PORTS(NUM_PORTS), .MAX_TRIES(MAX_TRIES), .ADDR_W(ADDR_W),
    .PORT_CTRL_ADDR(A_PC), .RST_CTRL_ADDR(A_RST), .STATUS_ADDR(A_STAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_bit_sel(rst_bit_sel),
    .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_done(reg_done), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .upl_req(upl_req), .upl_done(upl_done), .upl_err(upl_err),
    .busy(busy), .done(done), .ok(ok), .attempts(attempts), .err_code(err_code)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [31:0] pc_val;
  bit pc_rd_err, pc_wr_err;
  bit [9:0] rst_err_m, upl_err_m, stat_err_m;
  logic [31:0] stat_word [10];
  int n_pc_rd, n_pc_wr, n_rst, n_upl, n_stat, n_bad;
  logic [31:0] last_pc_wdata, last_rst_wdata;
  int t_pcwr, t_rst1, t_upl1;

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] word);
    pc_val = 32'h0; pc_rd_err = 0; pc_wr_err = 0;
    rst_err_m = '0; upl_err_m = '0; stat_err_m = '0;
    for (int i = 0; i < 10; i++) stat_word[i] = word;
    n_pc_rd = 0; n_pc_wr = 0; n_rst = 0; n_upl = 0; n_stat = 0; n_bad = 0;
    last_pc_wdata = 0; last_rst_wdata = 0; t_pcwr = 0; t_rst1 = 0; t_upl1 = 0;
  endtask

  task automatic run;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
  endtask

  // device and burst engine model
  initial begin
    int idx;
    forever begin
      @(negedge clk);
      cyc++;
      if (reg_done) begin
        reg_done = 0; reg_err = 0;
      end else if (reg_req) begin
        reg_done = 1; reg_err = 0; reg_rdata = 0;
        idx = (n_rst > 0) ? n_rst - 1 : 0;
        if (!reg_write && reg_addr == A_PC) begin
          n_pc_rd++; reg_rdata = pc_val; reg_err = pc_rd_err;
        end else if (reg_write && reg_addr == A_PC) begin
          n_pc_wr++; last_pc_wdata = reg_wdata; reg_err = pc_wr_err; t_pcwr = cyc;
        end else if (reg_write && reg_addr == A_RST) begin
          idx = (n_rst > 9) ? 9 : n_rst;
          n_rst++; last_rst_wdata = reg_wdata; reg_err = rst_err_m[idx];
          if (n_rst == 1) t_rst1 = cyc;
        end else if (!reg_write && reg_addr == A_STAT) begin
          n_stat++; reg_rdata = stat_word[idx]; reg_err = stat_err_m[idx];
        end else n_bad++;
      end
      if (upl_done) begin
        upl_done = 0; upl_err = 0;
      end else if (upl_req) begin
        idx = (n_rst > 0) ? n_rst - 1 : 0;
        n_upl++; upl_done = 1; upl_err = upl_err_m[idx];
        if (n_upl == 1) t_upl1 = cyc;
      end
    end
  end

  task automatic t_reset_state;
    @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!reg_req && !upl_req, "R1", "requests after reset", {reg_req, upl_req}, 0);
  endtask

  task automatic t_first_pass;
    setup(32'h8000_00FF);
    pc_val = 32'h0000_0120; rst_bit_sel = 0;
    run();
    chk(ok == 1, "R8", "ok", ok, 1);
    chk(attempts == 1, "R8", "attempts", attempts, 1);
    chk(err_code == 0, "R8", "err_code", err_code, 0);
    chk(n_pc_rd == 1 && last_pc_wdata == 32'h0000_013F, "R2", "inhibit write data",
        last_pc_wdata, 32'h13F);
    chk(t_rst1 - t_pcwr >= DRAIN_CYC && t_rst1 - t_pcwr <= DRAIN_CYC + 3, "R4",
        "drain gap", t_rst1 - t_pcwr, DRAIN_CYC + 2);
    chk(last_rst_wdata == 32'h8, "R5", "reset word sel0", last_rst_wdata, 8);
    chk(t_upl1 - t_rst1 >= RECOVER_CYC && t_upl1 - t_rst1 <= RECOVER_CYC + 3, "R6",
        "recover gap", t_upl1 - t_rst1, RECOVER_CYC + 2);
    chk(n_stat == 1 && n_bad == 0, "R7", "status reads", n_stat, 1);
    @(negedge clk);
    chk(!busy && !reg_req && !upl_req, "R1", "idle after run", busy, 0);
  endtask

  task automatic t_inhibit_fail(input bit on_write);
    setup(32'h8000_0000);
    pc_rd_err = !on_write; pc_wr_err = on_write;
    run();
    chk(ok == 0 && err_code == 1, "R3", "inhibit error code", err_code, 1);
    chk(attempts == 0, "R3", "attempts", attempts, 0);
    chk(n_rst == 0, "R3", "reset writes", n_rst, 0);
  endtask

  task automatic t_retry_mix;
    setup(32'h8000_0000);
    rst_bit_sel = 1;
    rst_err_m[0] = 1; upl_err_m[1] = 1; stat_err_m[2] = 1;
    stat_word[3] = 32'h0000_0000;
    run();
    chk(ok == 1 && attempts == 5, "R10", "attempts after mixed failures", attempts, 5);
    chk(err_code == 0, "R10", "err_code", err_code, 0);
    chk(n_pc_rd == 1 && n_pc_wr == 1, "R10", "inhibit not repeated", n_pc_rd, 1);
    chk(n_rst == 5 && n_upl == 4 && n_stat == 3, "R10", "access counts",
        {n_rst[7:0], n_upl[7:0], n_stat[7:0]}, 24'h050403);
    chk(last_rst_wdata == 32'h4, "R5", "reset word sel1", last_rst_wdata, 4);
    rst_bit_sel = 0;
  endtask

  task automatic t_exhaust(input logic [31:0] word, input logic [3:0] code);
    setup(word);
    run();
    chk(ok == 0 && attempts == AW'(MAX_TRIES), "R11", "exhausted attempts", attempts, MAX_TRIES);
    chk(n_rst == MAX_TRIES, "R11", "reset writes", n_rst, MAX_TRIES);
    chk(err_code == code, "R9", "cause priority", err_code, code);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    setup(32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_first_pass();
    t_inhibit_fail(0);
    t_inhibit_fail(1);
    t_retry_mix();
    t_exhaust(32'hF000_0000, 4'd5);
    t_exhaust(32'hD000_0000, 4'd6);
    t_exhaust(32'h9000_0000, 4'd7);
    t_exhaust(32'h0FFF_FFFF, 4'd8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule